// File: doc/BRIEF.md
# Transmit Event Flags and Dual Interrupt Router

This block keeps four transmitter events as sticky status flags. The events are: a frame has finished, the transmit buffer ran dry, the buffer was overfilled, and a ping was triggered. Hardware sets a flag with a one-cycle pulse on its event input. Software sets flags through a write-1 force register and clears them through a write-1 clear register. The force register lets software drive its interrupt handlers without a real event.

Two interrupt lines each have their own four-bit enable mask. Each line is a level that stays high while any flag enabled on that line is set. A separate DMA request pulses when a frame finishes, but only if the finished frame was a data frame and the DMA enable bit is set.

The register decode and the logic that detects the events sit outside this block. This block sees one write strobe per register and a shared write data bus.

Top module: `tx_event_irq`

## Requirements
- R1: After reset the status flags, both interrupt lines and the DMA request are 0.
- R2: A 1 on a hardware event input sets its flag on the next clock edge, and the flag then holds with no further stimulus. The flag positions are: bit 0 frame done, bit 1 buffer underrun, bit 2 buffer overrun, bit 3 ping triggered.
- R3: A clear write sets to 0 every flag whose write data bit (bits 3:0) is 1. Flags whose write data bit is 0 are unchanged.
- R4: A force write sets to 1 every flag whose write data bit (bits 3:0) is 1. Flags whose write data bit is 0 are unchanged.
- R5: When a hardware set or a force meets a clear on the same flag in the same cycle, the flag ends at 1.
- R6: The interrupt-enable write loads the line 1 mask from write data bits 3:0. Line 1 is high exactly while (status AND mask 1) is non-zero.
- R7: The same interrupt-enable write loads the line 2 mask from bits 11:8, using the same event order. Line 2 is high exactly while (status AND mask 2) is non-zero.
- R8: The DMA enable write loads the enable from write data bit 0. When the frame-done event arrives with a data frame type (0011 or 0100 to 0111) and the enable is 1, the DMA request is high for the following cycle.
- R9: No DMA request is issued when the enable is 0, when the frame type is ping (0000), error (1111) or a reserved code, or when a pulse arrives on any event other than frame done.
- R10: The DMA request is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_evt_i | input | N_EVT | Hardware event pulses, one per flag |
| frame_type_i | input | TYPE_W | Type code of the frame that is finishing, valid with hw_evt_i[0] |
| clr_we_i | input | 1 | Clear register write strobe |
| frc_we_i | input | 1 | Force register write strobe |
| ien_we_i | input | 1 | Interrupt-enable register write strobe |
| dma_we_i | input | 1 | DMA-enable register write strobe |
| wdata_i | input | DATA_W | Shared write data |
| status_o | output | N_EVT | Sticky status flags |
| irq1_o | output | 1 | Interrupt line 1 (level) |
| irq2_o | output | 1 | Interrupt line 2 (level) |
| dma_evt_o | output | 1 | DMA request pulse |

## Verification
The bench builds the block with its defaults: four events, a 4-bit frame type, a 16-bit write bus and the second mask at bit 8. With four flags the state space is small enough to sweep in full. Every status value is crossed with every mask value for both lines, and every status value with every clear pattern and every force pattern. All sixteen frame codes are tried with the DMA enable both off and on.

// File: rtl/tx_event_irq.sv
module tx_event_irq #(
  parameter int N_EVT  = 4,
  parameter int TYPE_W = 4,
  parameter int DATA_W = 16,
  parameter int L2_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  hw_evt_i,
  input  logic [TYPE_W-1:0] frame_type_i,
  input  logic              clr_we_i,
  input  logic              frc_we_i,
  input  logic              ien_we_i,
  input  logic              dma_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_EVT-1:0]  status_o,
  output logic              irq1_o,
  output logic              irq2_o,
  output logic              dma_evt_o
);
  localparam logic [TYPE_W-1:0] TY_NWORD = TYPE_W'(3);
  localparam logic [TYPE_W-1:0] TY_DLO   = TYPE_W'(4);
  localparam logic [TYPE_W-1:0] TY_DHI   = TYPE_W'(7);

  logic [N_EVT-1:0] sts_q, mask1_q, mask2_q;
  logic [N_EVT-1:0] clr_m, set_m;
  logic             dma_en_q, is_data;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign clr_m = clr_we_i ? wdata_i[N_EVT-1:0] : '0;
  assign set_m = hw_evt_i | (frc_we_i ? wdata_i[N_EVT-1:0] : '0);

  assign is_data = (frame_type_i == TY_NWORD) ||
                   (frame_type_i >= TY_DLO && frame_type_i <= TY_DHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q     <= '0;
      mask1_q   <= '0;
      mask2_q   <= '0;
      dma_en_q  <= 1'b0;
      dma_evt_o <= 1'b0;
    end else begin
      sts_q     <= (sts_q & ~clr_m) | set_m;
      dma_evt_o <= hw_evt_i[0] & is_data & dma_en_q;
      if (ien_we_i) begin
        mask1_q <= wdata_i[N_EVT-1:0];
        mask2_q <= wdata_i[L2_LSB +: N_EVT];
      end
      if (dma_we_i) dma_en_q <= wdata_i[0];
    end
  end

  assign status_o = sts_q;
  assign irq1_o   = |(sts_q & mask1_q);
  assign irq2_o   = |(sts_q & mask2_q);
endmodule

module tx_event_irq_chk #(
  parameter int N_EVT  = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_EVT-1:0]  hw_evt_i,
  input logic              clr_we_i,
  input logic              frc_we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [N_EVT-1:0]  status_o,
  input logic              irq1_o,
  input logic              irq2_o,
  input logic              dma_evt_o
);
  AST_HW_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_evt_i) |=> ((status_o & $past(hw_evt_i)) == $past(hw_evt_i))); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we_i && !frc_we_i && hw_evt_i == '0) |=> $stable(status_o)); // R2
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !frc_we_i && hw_evt_i == '0) |=> ((status_o & $past(wdata_i[N_EVT-1:0])) == '0)); // R3
  AST_FORCE_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    frc_we_i |=> ((status_o & $past(wdata_i[N_EVT-1:0])) == $past(wdata_i[N_EVT-1:0]))); // R4
  AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == '0) |-> (!irq1_o && !irq2_o)); // R6
  AST_DMA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_evt_o |=> !dma_evt_o); // R10
  AST_DMA_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_evt_o) |-> $past(hw_evt_i[0])); // R8
endmodule

bind tx_event_irq tx_event_irq_chk #(.N_EVT(N_EVT), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_evt_i(hw_evt_i), .clr_we_i(clr_we_i),
  .frc_we_i(frc_we_i), .wdata_i(wdata_i), .status_o(status_o),
  .irq1_o(irq1_o), .irq2_o(irq2_o), .dma_evt_o(dma_evt_o)
);

// File: tb/test_tx_event_irq.sv
module test_tx_event_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  hw_evt = '0;
  logic [3:0]  ftype = '0;
  logic        clr_we = 1'b0, frc_we = 1'b0, ien_we = 1'b0, dma_we = 1'b0;
  logic [15:0] wdata = '0;
  logic [3:0]  status;
  logic        irq1, irq2, dma_evt;
  int          errors = 0;
  int          checks = 0;

  always #4 clk = ~clk;

  tx_event_irq i_tx_event_irq (
    .clk(clk), .rst_n(rst_n), .hw_evt_i(hw_evt), .frame_type_i(ftype),
    .clr_we_i(clr_we), .frc_we_i(frc_we), .ien_we_i(ien_we), .dma_we_i(dma_we),
    .wdata_i(wdata), .status_o(status), .irq1_o(irq1), .irq2_o(irq2),
    .dma_evt_o(dma_evt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, registers updated by the following negedge
  task automatic step(input logic [3:0] hw, input logic [3:0] ty, input logic c,
                      input logic f, input logic ie, input logic de, input logic [15:0] wd);
    hw_evt = hw; ftype = ty; clr_we = c; frc_we = f; ien_we = ie; dma_we = de; wdata = wd;
    @(negedge clk);
    hw_evt = '0; ftype = '0; clr_we = 0; frc_we = 0; ien_we = 0; dma_we = 0; wdata = '0;
  endtask

  task automatic load_status(input logic [3:0] s);
    step('0, '0, 1, 0, 0, 0, 16'h000F);
    step('0, '0, 0, 1, 0, 0, {12'h0, s});
  endtask

  function automatic bit is_data(input int t);
    return t == 3 || (t >= 4 && t <= 7);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 status", status, 0);
    check("R1 irq", {irq1, irq2}, 0);
    check("R1 dma", dma_evt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: each hardware event sets its own bit and it sticks
    for (int k = 0; k < 4; k++) begin
      load_status('0);
      step(4'(1 << k), '0, 0, 0, 0, 0, '0);
      check("R2 set", status, 1 << k);
      step('0, '0, 0, 0, 0, 0, '0);
      step('0, '0, 0, 0, 0, 0, '0);
      check("R2 sticky", status, 1 << k);
    end

    // R3 / R4: full sweeps of status against clear and force patterns
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        load_status(4'(s));
        step('0, '0, 1, 0, 0, 0, 16'(c));
        check("R3 clear", status, s & ~c & 15);
        load_status(4'(s));
        step('0, '0, 0, 1, 0, 0, 16'(c));
        check("R4 force", status, (s | c) & 15);
      end
    end

    // R5: set beats clear in the same cycle
    for (int s = 0; s < 16; s++) begin
      load_status('0);
      step(4'(s), '0, 1, 0, 0, 0, 16'h000F);
      check("R5 hw vs clear", status, s);
    end

    // R6 / R7: every status against every mask, line 2 gets the inverse mask
    for (int m = 0; m < 16; m++) begin
      step('0, '0, 0, 0, 1, 0, {4'h0, 4'(~m), 4'h0, 4'(m)});
      for (int s = 0; s < 16; s++) begin
        load_status(4'(s));
        check("R6 irq1", irq1, ((s & m) != 0) ? 1 : 0);
        check("R7 irq2", irq2, ((s & ~m & 15) != 0) ? 1 : 0);
      end
    end
    load_status('0);

    // R8 / R9 / R10: every frame type with DMA enable off and on
    for (int en = 0; en < 2; en++) begin
      step('0, '0, 0, 0, 0, 1, 16'(en));
      for (int t = 0; t < 16; t++) begin
        step(4'b0001, 4'(t), 0, 0, 0, 0, '0);
        check((en == 1 && is_data(t)) ? "R8 dma" : "R9 dma", dma_evt,
              (en == 1 && is_data(t)) ? 1 : 0);
        step('0, '0, 0, 0, 0, 0, '0);
        check("R10 pulse end", dma_evt, 0);
      end
    end
    step(4'b1110, 4'd4, 0, 0, 0, 0, '0);
    check("R9 other event", dma_evt, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule